// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Control and Read Path

This block models the control logic of a one-time-programmable memory organized as 16-bit words, with an optional 8-bit byte view. It decodes an active-low chip select, an active-low output enable, an active-low program strobe, a word/byte selector and two digital flags. One flag means "programming voltage present". The other means "high voltage applied to address line 9". From these inputs it picks one of seven behaviours: read, program verify, identifier read, output disable, standby, program and program inhibit.

The cell array is a register array that starts out all ones. Programming can only clear bits. The data bus is presented as a driven value plus a per-bit drive-enable vector, which a pad ring turns into a tri-state bus. Read data is registered, so the outputs reflect the inputs sampled at the previous rising clock edge. In byte mode, the pin that carries data bit 15 in word mode becomes the lowest address bit (`byte_sel`) and picks which half of the word appears on the low lane.

Top module: `otp_mode_ctrl`

## Requirements
- R1: While reset is asserted, every cell is set to ones and `dout_en` and `dout` are zero. The first read after reset returns 16'hFFFF.
- R2: With `ce_n` high, the next cycle shows `dout_en` = 0 and `dout` = 0, whatever the value of `oe_n` (standby).
- R3: With `ce_n` low and `oe_n` high, the next cycle shows `dout_en` = 0 and `dout` = 0 (output disable).
- R4: In word mode (`word_mode` = 1), a read (`ce_n` = 0, `oe_n` = 0) gives `dout_en` = 16'hFFFF and `dout` = the addressed word one cycle later.
- R5: In byte mode (`word_mode` = 0), a read gives `dout_en` = 16'h00FF and `dout[15:8]` = 0. `dout[7:0]` is word bits 15:8 when `byte_sel` = 1 and word bits 7:0 when `byte_sel` = 0.
- R6: When `ce_n` = 0, `oe_n` = 1, `pgm_n` = 0 and `vpp_on` = 1 are all present at a rising edge, the addressed word becomes its old value AND `din`, so no bit returns to one.
- R7: No cell changes if `ce_n` = 1, `vpp_on` = 0 or `pgm_n` = 1 (program inhibit).
- R8: A read while `vpp_on` = 1 returns the array contents exactly as a normal read does (program verify).
- R9: With `id_hv` = 1 and `addr[ADDR_W-1:1]` all zero, a read returns the identifier in place of the array: `addr[0]` = 0 gives 16'h00C2 and `addr[0]` = 1 gives 16'h018A in word mode. In byte mode it gives C2h or 8Ah on `dout[7:0]`, with `byte_sel` ignored. If any of those upper address bits is one, the array is read.
- R10: Every identifier byte on `dout[7:0]` has odd parity, and its bit 7 serves as the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | Programming voltage present |
| id_hv | input | 1 | High voltage on address line 9 (identifier request) |
| word_mode | input | 1 | 1 = 16-bit word view, 0 = 8-bit byte view |
| byte_sel | input | 1 | Lowest address bit in byte mode (shares the bit-15 pin) |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Program data |
| dout | output | 16 | Registered output data |
| dout_en | output | 16 | Per-bit drive enable for the tri-state bus |

## Verification
A cell with a wrong value shows up on the first read of that address, one cycle after the read is presented, either as a bit that came back as one or as a cleared bit that should not have changed. Faults in the mode decode show up at once in `dout_en`: lanes driven during standby or output disable, or an upper lane driven in byte mode. Byte-half steering and identifier errors show up on the low lane in the same cycle. An error in the identifier address qualification only appears when `id_hv` is set together with a nonzero upper address.

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [15:0] MFR_ID = 16'h00C2,
  parameter logic [15:0] DEV_ID = 16'h018A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_on,
  input  logic              id_hv,
  input  logic              word_mode,
  input  logic              byte_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [15:0]       dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] cells [DEPTH];

  wire rd_go   = !ce_n && !oe_n;
  wire prog_go = !ce_n && oe_n && !pgm_n && vpp_on;
  wire id_go   = id_hv && (addr[ADDR_W-1:1] == '0);

  wire [15:0] word_v = id_go ? (addr[0] ? DEV_ID : MFR_ID) : cells[addr];
  wire [7:0]  half_v = (byte_sel && !id_go) ? word_v[15:8] : word_v[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      dout    <= '0;
      dout_en <= '0;
    end else begin
      if (prog_go) cells[addr] <= cells[addr] & din;
      dout_en <= !rd_go ? 16'h0000 : (word_mode ? 16'hFFFF : 16'h00FF);
      dout    <= !rd_go ? 16'h0000 : (word_mode ? word_v : {8'h00, half_v});
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ce_n)) |-> (dout_en == 16'h0000 && dout == 16'h0000));

  p_disable_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!ce_n && oe_n)) |-> (dout_en == 16'h0000));

  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rd_go && word_mode)) |-> (dout_en == 16'hFFFF));

  p_byte_upper_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!word_mode)) |-> (dout_en[15:8] == 8'h00 && dout[15:8] == 8'h00));

  p_id_odd_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rd_go && id_go)) |-> (^dout[7:0] == 1'b1));
endmodule

// File: tb/tb_otp_mode_ctrl.sv
module tb_otp_mode_ctrl;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, pgm_n, vpp_on, id_hv, word_mode, byte_sel;
  logic [AW-1:0] addr;
  logic [15:0] din, dout, dout_en;

  logic [15:0] model [DEPTH];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  otp_mode_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_on(vpp_on), .id_hv(id_hv), .word_mode(word_mode), .byte_sel(byte_sel),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  function automatic logic [15:0] exp_word();
    if (id_hv && addr[AW-1:1] == '0) return addr[0] ? 16'h018A : 16'h00C2;
    return model[addr];
  endfunction

  function automatic logic [15:0] exp_en();
    if (ce_n || oe_n) return 16'h0000;
    return word_mode ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] w;
    logic idq;
    if (ce_n || oe_n) return 16'h0000;
    w = exp_word();
    idq = id_hv && addr[AW-1:1] == '0;
    if (word_mode) return w;
    return {8'h00, (byte_sel && !idq) ? w[15:8] : w[7:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic o, input logic p,
                      input logic v, input logic h, input logic w, input logic b,
                      input logic [AW-1:0] a, input logic [15:0] d);
    logic [15:0] e_en, e_out;
    ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; id_hv = h;
    word_mode = w; byte_sel = b; addr = a; din = d;
    e_en = exp_en();
    e_out = exp_out();
    @(posedge clk);
    if (!c && o && !p && v) model[a] = model[a] & d;
    @(negedge clk);
    check({tag, " en"}, dout_en, e_en);
    check({tag, " data"}, dout, e_out);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_on = 1'b0;
    id_hv = 1'b0; word_mode = 1'b1; byte_sel = 1'b0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R1 reset en", dout_en, 16'h0000);
    check("R1 reset data", dout, 16'h0000);
    rst_n = 1'b1;

    step("R1 erased", 0, 0, 1, 0, 0, 1, 0, 8'd0, 16'h0000);
    step("R1 erased top", 0, 0, 1, 0, 0, 1, 0, 8'd255, 16'h0000);
    step("R6 prog", 0, 1, 0, 1, 0, 1, 0, 8'd5, 16'h1234);
    step("R4 read", 0, 0, 1, 0, 0, 1, 0, 8'd5, 16'h0000);
    step("R6 and", 0, 1, 0, 1, 0, 1, 0, 8'd5, 16'hFF00);
    step("R6 readback", 0, 0, 1, 0, 0, 1, 0, 8'd5, 16'h0000);
    step("R6 no set", 0, 1, 0, 1, 0, 1, 0, 8'd5, 16'hFFFF);
    step("R8 verify", 0, 0, 1, 1, 0, 1, 0, 8'd5, 16'h0000);
    step("R7 ce high", 1, 1, 0, 1, 0, 1, 0, 8'd9, 16'h0000);
    step("R7 no vpp", 0, 1, 0, 0, 0, 1, 0, 8'd9, 16'h0000);
    step("R7 pgm high", 0, 1, 1, 1, 0, 1, 0, 8'd9, 16'h0000);
    step("R7 readback", 0, 0, 1, 0, 0, 1, 0, 8'd9, 16'h0000);
    step("R2 standby oe low", 1, 0, 1, 0, 0, 1, 0, 8'd5, 16'h0000);
    step("R3 out disable", 0, 1, 1, 0, 0, 1, 0, 8'd5, 16'h0000);
    step("R6 prog b", 0, 1, 0, 1, 0, 1, 0, 8'd7, 16'hA55A);
    step("R5 byte lo", 0, 0, 1, 0, 0, 0, 0, 8'd7, 16'h0000);
    step("R5 byte hi", 0, 0, 1, 0, 0, 0, 1, 8'd7, 16'h0000);
    step("R9 mfr word", 0, 0, 1, 0, 1, 1, 0, 8'd0, 16'h0000);
    step("R9 dev word", 0, 0, 1, 0, 1, 1, 0, 8'd1, 16'h0000);
    step("R10 mfr byte", 0, 0, 1, 0, 1, 0, 1, 8'd0, 16'h0000);
    step("R10 dev byte", 0, 0, 1, 0, 1, 0, 1, 8'd1, 16'h0000);
    step("R9 upper addr", 0, 0, 1, 0, 1, 1, 0, 8'd5, 16'h0000);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] k;
      logic [AW-1:0] a;
      k = 4'($urandom % 16);
      a = (k[0]) ? AW'($urandom % 4) : AW'($urandom % DEPTH);
      if (k < 4'd5)
        step("RND prog", 0, 1, 0, 1, 0, 1, 0, a, 16'($urandom));
      else
        step("RND mix", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), a, 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule